// File: doc/BRIEF.md
# Rate-Scaled Operator Envelope Generator

This block shapes the loudness of one operator in an FM synthesizer. It keeps a 9-bit attenuation level, where 0 is loudest and 0x1FF is silent. The level moves through five phases: idle, an exponential rise, a linear fall to a sustain floor, an optional hold, and a linear fade back to silence. The key input starts and ends a note.

Each phase has a 4-bit rate. The rate is scaled by the note's octave and frequency, and the global sample timer controls when steps happen. At slow rates, steps come only on timer values whose low bits are all zero. At faster rates, steps come on every sample, and a fixed 8-entry pattern selected by the timer decides how large each step is. The block also outputs the total attenuation for the waveform stage. This is the level plus the total-level offset, a pitch-dependent key-scale term and the tremolo value.

One clock cycle is one sample. The timer input is shared by all operators, and the block samples it on every edge.

Top module: `fm_env_gen`

## Requirements
- R1: On reset the phase is idle and the level is 0x1FF. Phase codes on `env_state` are: idle 0, rise 1, fall 2, sustain 3, fade 4.
- R2: The effective rate is 0 when the selected 4-bit rate is 0. Otherwise it is rate×4 plus a scale term, limited to 60. The scale value is {block, f}, where f is `fnum_top[3]` (frequency bit 9) when `note_sel` is 0 and `fnum_top[2]` (bit 8) when `note_sel` is 1. The scale term is that full 4-bit value when `ksr_en` is 1, and the value shifted right by two otherwise. The rise phase uses `ar`, the fall phase uses `dr`, and sustain and fade use `rr`.
- R3: Let g = effective rate >> 2 and j = effective rate & 3. For g in 1..11, with s = 12−g, a step happens only when timer bits [s−1:0] are all zero, and the step is pattern[(timer>>s)&7]. For g 0 and 12..15 the step is pattern[timer&7], shifted left by 1 for g=14 and by 2 for g=15. The pattern table, entries 0..7 left to right, is chosen by j. For g=0 every entry is 0. For g=1..12 the rows are 01010101, 01011101, 01110111, 01111111. For g=13..15 the rows are 11111111, 22111111, 22112211, 22222211.
- R4: In the rise phase, a nonzero level L becomes max(0, L + floor(−(L+1)×step/8)). A level of 0 moves the block to the fall phase.
- R5: A rising edge on `key` takes effect at the next clock edge, in place of that sample's step, and enters the rise phase. If the rise rate gives g = 15, the block enters the fall phase with the level at 0 instead.
- R6: On a key rising edge with `ar` = 0, the block enters the fall phase and the level rises by one, saturating at 0x1FF.
- R7: In the fall phase the level grows by the step while it is below floor×16. Otherwise the block moves to sustain. Sustain codes 0..14 give floor = code, and code 15 gives floor = 31.
- R8: In sustain with `hold` set, the level does not change.
- R9: In fade, and in sustain without `hold`, the level grows by the step, saturating at 0x1FF. Once the level reaches 0x1FF, the block goes idle with the level at 0x1FF. In idle the level is always 0x1FF.
- R10: A falling edge on `key` enters the fade phase at the next clock edge.
- R11: `atten` is combinational: level + tl×4 + (ksl >> {8,1,2,0}[ksl_sel]) + trem. Here ksl = clamp(T[fnum_top]×4 − (8−block)×32, 0, 255), with T = 0,32,40,45,48,51,53,55,56,58,59,60,61,62,63,64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one edge per sample |
| rst_n | input | 1 | Asynchronous active-low reset |
| key | input | 1 | Note gate; edges start and end notes |
| ar | input | 4 | Rise rate |
| dr | input | 4 | Fall rate |
| sl | input | 4 | Sustain floor code |
| rr | input | 4 | Fade rate |
| hold | input | 1 | Hold level in sustain |
| ksr_en | input | 1 | Full key-scale rate term |
| tl | input | 6 | Total-level offset |
| ksl_sel | input | 2 | Key-scale-level depth select |
| fnum_top | input | 4 | Frequency number bits 9..6 |
| block | input | 3 | Octave |
| note_sel | input | 1 | Picks frequency bit 8 instead of bit 9 for rate scaling |
| trem | input | TREM_W (5) | Tremolo attenuation |
| timer | input | TIMER_W (16) | Global sample counter |
| env_state | output | 3 | Current phase code |
| env_level | output | 9 | Current envelope level |
| atten | output | OUT_W (12) | Total attenuation to the waveform stage |

## Verification
The phase and level are registered. A key edge or a timer value that the bench applies shows up on `env_state` and `env_level` one clock edge later. `atten` depends combinationally on the level and the offset inputs, so it changes in the same cycle those inputs change. The bench drives its inputs 1 ns after a rising edge and reads results 1 ns after the following edge, which is the first point where a registered result is due. Multi-step sequences are counted edge by edge from the key event, so each expected level is tied to a specific sample.

// File: rtl/fm_env_gen.sv
module fm_env_gen #(
  parameter int TIMER_W = 16,
  parameter int TREM_W  = 5,
  localparam int OUT_W  = ((TREM_W > 10) ? TREM_W : 10) + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               key,
  input  logic [3:0]         ar,
  input  logic [3:0]         dr,
  input  logic [3:0]         sl,
  input  logic [3:0]         rr,
  input  logic               hold,
  input  logic               ksr_en,
  input  logic [5:0]         tl,
  input  logic [1:0]         ksl_sel,
  input  logic [3:0]         fnum_top,
  input  logic [2:0]         block,
  input  logic               note_sel,
  input  logic [TREM_W-1:0]  trem,
  input  logic [TIMER_W-1:0] timer,
  output logic [2:0]         env_state,
  output logic [8:0]         env_level,
  output logic [OUT_W-1:0]   atten
);

  localparam logic [8:0] LVL_MAX = 9'h1FF;
  localparam logic [5:0] RATE_CAP = 6'd60;

  typedef enum logic [2:0] {
    EG_OFF = 3'd0, EG_ATK = 3'd1, EG_DEC = 3'd2, EG_SUS = 3'd3, EG_REL = 3'd4
  } eg_state_t;

  eg_state_t  state_q, state_d;
  logic [8:0] lvl_q, lvl_d;
  logic       key_q;

  function automatic logic [5:0] eff_rate(input logic [3:0] r, input logic [3:0] ks,
                                          input logic full);
    logic [6:0] sum;
    if (r == 4'd0) return 6'd0;
    sum = {1'b0, r, 2'b00} + (full ? {3'b000, ks} : {5'b00000, ks[3:2]});
    return (sum > 7'(RATE_CAP)) ? RATE_CAP : sum[5:0];
  endfunction

  function automatic logic [1:0] pat(input logic [1:0] grp, input logic [1:0] row,
                                     input logic [2:0] i);
    logic [1:0] v;
    v = 2'd0;
    if (grp == 2'd1) begin
      case (row)
        2'd0: v = {1'b0, i[0]};
        2'd1: v = {1'b0, i[0] | (i == 3'd4)};
        2'd2: v = {1'b0, i[1:0] != 2'd0};
        default: v = {1'b0, i != 3'd0};
      endcase
    end else if (grp == 2'd2) begin
      case (row)
        2'd0: v = 2'd1;
        2'd1: v = (i < 3'd2) ? 2'd2 : 2'd1;
        2'd2: v = (i[1] == 1'b0) ? 2'd2 : 2'd1;
        default: v = (i < 3'd6) ? 2'd2 : 2'd1;
      endcase
    end
    return v;
  endfunction

  function automatic logic [6:0] ksl_base(input logic [3:0] idx);
    case (idx)
      4'd0:  return 7'd0;   4'd1:  return 7'd32;  4'd2:  return 7'd40;  4'd3:  return 7'd45;
      4'd4:  return 7'd48;  4'd5:  return 7'd51;  4'd6:  return 7'd53;  4'd7:  return 7'd55;
      4'd8:  return 7'd56;  4'd9:  return 7'd58;  4'd10: return 7'd59;  4'd11: return 7'd60;
      4'd12: return 7'd61;  4'd13: return 7'd62;  4'd14: return 7'd63;  default: return 7'd64;
    endcase
  endfunction

  logic [3:0] ksr_val;
  logic [5:0] atk_rate, cur_rate;
  logic [3:0] hi, sh, inc;
  logic [1:0] lo, grp;
  logic [2:0] tidx;
  logic       gate;
  logic [9:0] sum_add;
  logic [8:0] lvl_add, lvl_atk, sl_lim;
  logic [7:0] ksl_c, ksl_part;
  logic       key_rise, key_fall;

  assign ksr_val  = {block, note_sel ? fnum_top[2] : fnum_top[3]};
  assign atk_rate = eff_rate(ar, ksr_val, ksr_en);
  assign key_rise = key & ~key_q;
  assign key_fall = ~key & key_q;

  always_comb begin
    case (state_q)
      EG_ATK:         cur_rate = atk_rate;
      EG_DEC:         cur_rate = eff_rate(dr, ksr_val, ksr_en);
      EG_SUS, EG_REL: cur_rate = eff_rate(rr, ksr_val, ksr_en);
      default:        cur_rate = 6'd0;
    endcase
  end

  assign hi = cur_rate[5:2];
  assign lo = cur_rate[1:0];

  always_comb begin
    sh   = 4'd12 - hi;
    grp  = (hi == 4'd0) ? 2'd0 : ((hi >= 4'd13) ? 2'd2 : 2'd1);
    gate = 1'b1;
    tidx = timer[2:0];
    if (hi != 4'd0 && hi <= 4'd11) begin
      gate = ((timer & ((TIMER_W'(1) << sh) - TIMER_W'(1))) == '0);
      tidx = 3'(timer >> sh);
    end
    inc = gate ? {2'b00, pat(grp, lo, tidx)} : 4'd0;
    if (hi == 4'd14)      inc = inc << 1;
    else if (hi == 4'd15) inc = inc << 2;
  end

  always_comb begin : atk_step
    int nxt;
    nxt     = int'(lvl_q) + ((-(int'(lvl_q) + 1) * int'(inc)) >>> 3);
    lvl_atk = (nxt < 0) ? 9'd0 : 9'(nxt);
  end

  assign sum_add = {1'b0, lvl_q} + {6'd0, inc};
  assign lvl_add = (sum_add > {1'b0, LVL_MAX}) ? LVL_MAX : sum_add[8:0];
  assign sl_lim  = {((sl == 4'hF) ? 5'd31 : {1'b0, sl}), 4'b0000};

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    if (key_rise) begin
      state_d = EG_ATK;
      if (atk_rate[5:2] == 4'hF) begin
        state_d = EG_DEC;
        lvl_d   = 9'd0;
      end
      if (ar == 4'd0) begin
        state_d = EG_DEC;
        lvl_d   = (lvl_q == LVL_MAX) ? LVL_MAX : lvl_q + 9'd1;
      end
    end else if (key_fall) begin
      state_d = EG_REL;
    end else begin
      case (state_q)
        EG_OFF: lvl_d = LVL_MAX;
        EG_ATK: if (lvl_q != 9'd0) lvl_d = lvl_atk; else state_d = EG_DEC;
        EG_DEC: if (lvl_q < sl_lim) lvl_d = lvl_add; else state_d = EG_SUS;
        EG_SUS, EG_REL: begin
          if (!(state_q == EG_SUS && hold)) begin
            if (lvl_q < LVL_MAX) lvl_d = lvl_add;
            else begin
              state_d = EG_OFF;
              lvl_d   = LVL_MAX;
            end
          end
        end
        default: begin
          state_d = EG_OFF;
          lvl_d   = LVL_MAX;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EG_OFF;
      lvl_q   <= LVL_MAX;
      key_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      key_q   <= key;
    end
  end

  always_comb begin : ksl_calc
    int k;
    k     = int'(ksl_base(fnum_top)) * 4 - (8 - int'(block)) * 32;
    ksl_c = (k < 0) ? 8'd0 : ((k > 255) ? 8'd255 : 8'(k));
    case (ksl_sel)
      2'd0:    ksl_part = 8'd0;
      2'd1:    ksl_part = ksl_c >> 1;
      2'd2:    ksl_part = ksl_c >> 2;
      default: ksl_part = ksl_c;
    endcase
  end

  assign atten = OUT_W'(lvl_q) + OUT_W'({tl, 2'b00}) + OUT_W'(ksl_part) + OUT_W'(trem);
  assign env_state = state_q;
  assign env_level = lvl_q;

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == EG_OFF) |-> (lvl_q == LVL_MAX)); // R9

  AST_RISE_NEVER_QUIETER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == EG_ATK && key == key_q) |=> (lvl_q <= $past(lvl_q))); // R4

  AST_SUSTAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == EG_SUS && hold && key == key_q) |=> $stable(lvl_q)); // R8

  AST_KEY_OFF_FADES: assert property (@(posedge clk) disable iff (!rst_n)
    (!key && key_q) |=> (state_q == EG_REL)); // R10

  AST_TOP_RATE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (key && !key_q && atk_rate[5:2] == 4'hF) |=> (state_q == EG_DEC && lvl_q == 9'd0)); // R5

endmodule

// File: tb/fm_env_gen_tb.sv
module fm_env_gen_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, key, hold, ksr_en, note_sel;
  logic [3:0]  ar, dr, sl, rr, fnum_top;
  logic [5:0]  tl;
  logic [1:0]  ksl_sel;
  logic [2:0]  block;
  logic [4:0]  trem;
  logic [15:0] timer;
  logic [2:0]  env_state;
  logic [8:0]  env_level;
  logic [11:0] atten;

  fm_env_gen u_dut (
    .clk(clk), .rst_n(rst_n), .key(key), .ar(ar), .dr(dr), .sl(sl), .rr(rr),
    .hold(hold), .ksr_en(ksr_en), .tl(tl), .ksl_sel(ksl_sel), .fnum_top(fnum_top),
    .block(block), .note_sel(note_sel), .trem(trem), .timer(timer),
    .env_state(env_state), .env_level(env_level), .atten(atten)
  );

  int checks = 0;
  int failures = 0;

  // {fnum_top, block, ksl_sel, tl, trem, expected atten} with the block idle (level 0x1FF)
  localparam logic [31:0] KVEC [8] = '{
    {4'hF, 3'd7, 2'd3, 6'd0,  5'd0,  12'd735},
    {4'hF, 3'd7, 2'd1, 6'd10, 5'd3,  12'd666},
    {4'hF, 3'd7, 2'd2, 6'd63, 5'd26, 12'd845},
    {4'hF, 3'd7, 2'd0, 6'd0,  5'd0,  12'd511},
    {4'h1, 3'd7, 2'd3, 6'd0,  5'd0,  12'd607},
    {4'h1, 3'd4, 2'd3, 6'd0,  5'd0,  12'd511},
    {4'h0, 3'd0, 2'd3, 6'd1,  5'd0,  12'd515},
    {4'h8, 3'd6, 2'd3, 6'd0,  5'd0,  12'd671}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_se(input string tag, input int st, input int lv);
    chk({tag, " state"}, int'(env_state), st);
    chk({tag, " level"}, int'(env_level), lv);
  endtask

  task automatic defaults();
    key = 0; ar = 0; dr = 0; sl = 0; rr = 0; hold = 0; ksr_en = 0; note_sel = 0;
    tl = 0; ksl_sel = 0; fnum_top = 0; block = 0; trem = 0; timer = 16'd1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    key = 0;
    tick();
    tick();
    rst_n = 1;
  endtask

  logic [11:0] exp_a;

  initial begin
    defaults();
    do_reset();
    expect_se("R1 reset", 0, 511);

    for (int i = 0; i < 8; i++) begin
      {fnum_top, block, ksl_sel, tl, trem, exp_a} = KVEC[i];
      #1;
      chk($sformatf("R11 vector %0d atten", i), int'(atten), int'(exp_a));
    end

    // R5 instant rise, R7 floor 0, R8 hold, R10 key-off, R9 fade and idle
    defaults(); do_reset();
    ar = 15; rr = 15; hold = 1;
    key = 1; tick();
    expect_se("R5 top rate", 2, 0);
    tick();
    expect_se("R7 floor zero", 3, 0);
    tick(); tick(); tick();
    expect_se("R8 hold", 3, 0);
    key = 0; tick();
    expect_se("R10 key-off", 4, 0);
    tick();
    expect_se("R9 fade step1", 4, 4);
    chk("R11 atten in fade", int'(atten), 4);
    tick();
    expect_se("R9 fade step2", 4, 8);
    repeat (140) tick();
    expect_se("R9 fade to idle", 0, 511);

    // R6 zero rise rate, R7 code 15, R9 sustain without hold
    defaults(); do_reset();
    sl = 15;
    key = 1; tick();
    expect_se("R6 fake fall", 2, 511);
    tick();
    expect_se("R7 code15 floor", 3, 511);
    tick();
    expect_se("R9 sustain no hold", 0, 511);

    // R4 exponential rise and R12 key edge replaces the step
    defaults(); do_reset();
    ar = 13;
    key = 1; tick();
    expect_se("R12 key-on no step", 1, 511);
    tick(); expect_se("R4 rise1", 1, 447);
    tick(); expect_se("R4 rise2", 1, 391);
    tick(); expect_se("R4 rise3", 1, 342);

    // R3 timer gating at a slow rate
    defaults(); do_reset();
    ar = 1;
    key = 1; tick();
    tick();
    expect_se("R3 gated low bits", 1, 511);
    timer = 16'h0800; tick();
    expect_se("R3 odd pattern slot", 1, 447);
    timer = 16'h1000; tick();
    expect_se("R3 even pattern slot", 1, 447);

    // R2 scale term and note select, R3 row choice in group three
    defaults(); do_reset();
    ar = 13; ksr_en = 1; fnum_top = 4'h8; timer = 16'd0;
    key = 1; tick(); tick();
    chk("R2 note_sel0 full scale", int'(env_level), 383);
    defaults(); do_reset();
    ar = 13; ksr_en = 1; fnum_top = 4'h8; note_sel = 1; timer = 16'd0;
    key = 1; tick(); tick();
    chk("R2 note_sel1 full scale", int'(env_level), 447);
    defaults(); do_reset();
    ar = 13; ksr_en = 0; fnum_top = 4'h8; timer = 16'd0;
    key = 1; tick(); tick();
    chk("R2 reduced scale", int'(env_level), 447);

    // R2 rate limit of 60 reaches the top group
    defaults(); do_reset();
    ar = 14; ksr_en = 1; block = 7; fnum_top = 4'h8;
    key = 1; tick();
    expect_se("R2 rate clamp", 2, 0);

    // R7 fall to floor code 1
    defaults(); do_reset();
    ar = 15; dr = 13; sl = 1; hold = 1;
    key = 1; tick();
    repeat (16) tick();
    expect_se("R7 fall reaching floor", 2, 16);
    tick();
    expect_se("R7 enter sustain", 3, 16);
    tick();
    expect_se("R8 hold at floor", 3, 16);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule